// File: doc/BRIEF.md
# NAND Access Phase Timing Sequencer

This block produces the strobe timing for a single read or write access to the common memory space of a NAND flash device. A start request, together with a direction flag and a 32-bit timing word, launches the access. The timing word carries four 8-bit counts: setup, command, hold and bus-release. At the moment of acceptance the block copies the word and the direction flag, so the caller may change its inputs while the access is still running.

The sequencer moves through five named states. `ST_IDLE` waits for a start. `ST_SETUP` presents a valid address ahead of the command strobe. `ST_CMD` holds the selected strobe low for the programmed minimum. `ST_STRETCH` keeps the strobe low while the device reports that it is busy. `ST_HOLD` keeps the address, and on writes the data, valid once the strobe has been released. The named transitions are:

- start-accept: IDLE to SETUP
- setup-expire: SETUP to CMD
- cmd-expire-ready: CMD to HOLD
- cmd-expire-busy: CMD to STRETCH
- wait-release: STRETCH to HOLD
- hold-expire: HOLD to IDLE

The wait input is active low and passes through a two-stage synchronizer. On a write, the data-drive enable stays low for a programmable number of cycles counted from the first setup cycle. It then rises and stays high until the access ends.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset, both strobes are high, and the address-valid, data-drive and done outputs are low.
- R2: Timing word bits 7:0 hold the setup count S. Address-valid is high with both strobes high for S+1 cycles before the command strobe falls. The first of these cycles is the cycle right after the start is accepted.
- R3: Timing word bits 15:8 hold the command count C. The command strobe stays low for C+1 cycles when the synchronized wait input is high in the last of those cycles.
- R4: If the synchronized wait input is low in the last programmed command cycle, the strobe stays low. It then rises on the third clock edge after the wait input pin goes high.
- R5: Timing word bits 23:16 hold the hold count H. After the strobe rises, address-valid stays high for H cycles on a write (at least 1) and H+1 cycles on a read.
- R6: Timing word bits 31:24 hold the bus-release count Z. On a write, data-drive goes high in cycle Z, counting the first setup cycle as 0, and stays high through the last hold cycle.
- R7: On a read (direction flag 0), data-drive stays low for the whole access.
- R8: Done is high for exactly one cycle, the last hold cycle. The next cycle is idle, with both strobes high and address-valid low.
- R9: A start or a change of timing word or direction during an access has no effect on that access, and it does not launch a second access.
- R10: Only the strobe for the latched direction moves: write enable when the direction flag is 1, read enable when it is 0.
- R11: The wait input is checked only in the last programmed command cycle. A wait that is low earlier but high by then does not lengthen the command phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access request, taken only when idle |
| is_write_i | input | 1 | 1 = write access, 0 = read access |
| timing_i | input | 32 | Timing word {release, hold, command, setup} |
| wait_n_i | input | 1 | Active-low device busy, asynchronous |
| we_n_o | output | 1 | Active-low write strobe |
| re_n_o | output | 1 | Active-low read strobe |
| addr_valid_o | output | 1 | Address must be driven |
| data_drive_o | output | 1 | Write data may be driven onto the bus |
| done_o | output | 1 | One-cycle pulse on the last hold cycle |

## Verification
A table of accesses measures the length of each phase, the first data-drive cycle and the position of done. The accesses include all-zero counts, a zero hold count on a write, a bus-release count beyond the end of the access, and the reset value of all fields at 0xFC, which together separate the write and read hold rules. Two directed wait patterns check timing. A wait held low past the programmed command time must stretch the strobe by an exact, known delay. A wait released during setup must not stretch it, which pins down when the wait input is sampled. A separate access changes start, direction and timing while it runs, and the phase lengths must still follow the values captured at acceptance.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int FIELD_W = 8;
    localparam int CNT_W   = FIELD_W + 1;
    localparam logic [4*FIELD_W-1:0] TIMING_RST = 32'hFCFC_FCFC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_STRETCH,
        ST_HOLD
    } phase_e;

    // Packed order puts the first member at the top bits.
    typedef struct packed {
        logic [FIELD_W-1:0] release_cnt;
        logic [FIELD_W-1:0] hold_cnt;
        logic [FIELD_W-1:0] cmd_cnt;
        logic [FIELD_W-1:0] setup_cnt;
    } timing_t;
endpackage

// File: rtl/nand_wait_sync.sv
module nand_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nand_phase_cnt.sv
module nand_phase_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_o <= '0;
        else if (clr_i)              cnt_o <= '0;
        else if (cnt_o != CNT_MAX)   cnt_o <= cnt_o + 1'b1;
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)); // R2
endmodule

// File: rtl/nand_hiz_win.sv
module nand_hiz_win #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch_i,
    input  logic         busy_i,
    input  logic [W-1:0] limit_i,
    output logic         open_o
);
    localparam int EW = W + 1;
    localparam logic [EW-1:0] EL_MAX = '1;

    logic [EW-1:0] elapsed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                elapsed_q <= '0;
        else if (launch_i)                         elapsed_q <= '0;
        else if (busy_i && elapsed_q != EL_MAX)    elapsed_q <= elapsed_q + 1'b1;
    end

    assign open_o = busy_i && (elapsed_q >= {1'b0, limit_i});

    AST_WINDOW_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && busy_i) |=> (open_o || !busy_i)); // R6
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
    import nand_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  timing_t          timing_i,
    input  logic             wait_s_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             hiz_open_i,
    output logic             cnt_clr_o,
    output logic             launch_o,
    output logic             busy_o,
    output logic [FIELD_W-1:0] release_o,
    output logic             we_n_o,
    output logic             re_n_o,
    output logic             addr_valid_o,
    output logic             data_drive_o,
    output logic             done_o
);
    phase_e  state_q, state_d;
    timing_t cfg_q;
    logic    wr_q;

    logic [CNT_W-1:0] setup_last, cmd_last, hold_last;
    logic             setup_end, cmd_end, hold_end;

    assign setup_last = {1'b0, cfg_q.setup_cnt};
    assign cmd_last   = {1'b0, cfg_q.cmd_cnt};
    // Writes hold for H cycles (never fewer than one), reads for H+1.
    assign hold_last  = wr_q ? ((cfg_q.hold_cnt == '0) ? '0 : {1'b0, cfg_q.hold_cnt} - 1'b1)
                             : {1'b0, cfg_q.hold_cnt};

    assign setup_end = (cnt_i == setup_last);
    assign cmd_end   = (cnt_i == cmd_last);
    assign hold_end  = (cnt_i == hold_last);

    assign launch_o  = (state_q == ST_IDLE) && start_i;
    assign busy_o    = (state_q != ST_IDLE);
    assign release_o = cfg_q.release_cnt;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)   state_d = ST_SETUP;
            ST_SETUP:   if (setup_end) state_d = ST_CMD;
            ST_CMD:     if (cmd_end)   state_d = wait_s_i ? ST_HOLD : ST_STRETCH;
            ST_STRETCH: if (wait_s_i)  state_d = ST_HOLD;
            ST_HOLD:    if (hold_end)  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    assign cnt_clr_o = (state_d != state_q) || (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Access parameters captured at start-accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= timing_t'(TIMING_RST);
            wr_q  <= 1'b0;
        end else if (launch_o) begin
            cfg_q <= timing_i;
            wr_q  <= is_write_i;
        end
    end

    // Output decode
    always_comb begin
        we_n_o       = 1'b1;
        re_n_o       = 1'b1;
        addr_valid_o = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: addr_valid_o = 1'b1;
            ST_CMD, ST_STRETCH: begin
                addr_valid_o = 1'b1;
                if (wr_q) we_n_o = 1'b0;
                else      re_n_o = 1'b0;
            end
            ST_HOLD: begin
                addr_valid_o = 1'b1;
                done_o       = hold_end;
            end
            default: ;
        endcase
        data_drive_o = wr_q && busy_o && hiz_open_i;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(cfg_q)); // R9
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!addr_valid_o && we_n_o && re_n_o && !done_o)); // R8
    AST_STRETCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH && !wait_s_i) |=> (state_q == ST_STRETCH)); // R4
    AST_CMD_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && $past(state_q) != ST_CMD) |-> ($past(state_q) == ST_SETUP)); // R2
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_o || !re_n_o) |-> (we_n_o != re_n_o)); // R10
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wr_q) |-> !data_drive_o); // R7
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nand_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        is_write_i,
    input  logic [31:0] timing_i,
    input  logic        wait_n_i,
    output logic        we_n_o,
    output logic        re_n_o,
    output logic        addr_valid_o,
    output logic        data_drive_o,
    output logic        done_o
);
    logic               wait_s;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_clr;
    logic               launch;
    logic               busy;
    logic               hiz_open;
    logic [FIELD_W-1:0] release_cnt;

    nand_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wait_n_i),
        .sync_o  (wait_s)
    );

    nand_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    nand_hiz_win #(.W(FIELD_W)) u_hiz (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .busy_i   (busy),
        .limit_i  (release_cnt),
        .open_o   (hiz_open)
    );

    nand_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .is_write_i   (is_write_i),
        .timing_i     (timing_t'(timing_i)),
        .wait_s_i     (wait_s),
        .cnt_i        (cnt),
        .hiz_open_i   (hiz_open),
        .cnt_clr_o    (cnt_clr),
        .launch_o     (launch),
        .busy_o       (busy),
        .release_o    (release_cnt),
        .we_n_o       (we_n_o),
        .re_n_o       (re_n_o),
        .addr_valid_o (addr_valid_o),
        .data_drive_o (data_drive_o),
        .done_o       (done_o)
    );

    AST_DRIVE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        data_drive_o |-> addr_valid_o); // R6
endmodule

// File: tb/sim_nand_phase_seq.sv
module sim_nand_phase_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    typedef struct packed {
        logic        wr;
        logic [31:0] timing;
        int          e_setup;
        int          e_cmd;
        int          e_hold;
        int          e_drive;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_0000,   1,   1,   1,   0},
        '{1'b1, 32'h0000_0000,   1,   1,   1,   3},
        '{1'b1, 32'h0503_0204,   5,   3,   3,   6},
        '{1'b0, 32'h0503_0204,   5,   3,   4,   0},
        '{1'b1, 32'h2001_0002,   3,   1,   1,   0},
        '{1'b1, 32'h0300_0100,   1,   2,   1,   1},
        '{1'b0, 32'h0007_0501,   2,   6,   8,   0},
        '{1'b1, 32'hFCFC_FCFC, 253, 253, 252, 506}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_write_i = 1'b0;
    logic [31:0] timing_i = '0;
    logic        wait_n_i = 1'b1;
    logic        we_n_o, re_n_o, addr_valid_o, data_drive_o, done_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    nand_phase_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .is_write_i   (is_write_i),
        .timing_i     (timing_i),
        .wait_n_i     (wait_n_i),
        .we_n_o       (we_n_o),
        .re_n_o       (re_n_o),
        .addr_valid_o (addr_valid_o),
        .data_drive_o (data_drive_o),
        .done_o       (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Launch one access and measure its phases at negedges.
    // rel_idx: cycle after which wait_n is driven high (-1: untouched).
    // poke: disturb start/direction/timing during the access.
    task automatic run_access(input logic wr, input logic [31:0] tw, input int rel_idx,
                              input logic poke,
                              output int n_setup, output int n_cmd, output int n_hold,
                              output int n_drive, output int first_drv, output int done_idx,
                              output int n_done, output int wrong_strobe, output logic idle_after);
        logic strobe_low;
        n_setup = 0; n_cmd = 0; n_hold = 0; n_drive = 0; first_drv = -1;
        done_idx = -1; n_done = 0; wrong_strobe = 0; idle_after = 1'b0;
        @(negedge clk);
        start_i = 1'b1; is_write_i = wr; timing_i = tw;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int idx = 0; idx < 2000; idx++) begin
            strobe_low = wr ? !we_n_o : !re_n_o;
            if (wr ? !re_n_o : !we_n_o) wrong_strobe++;
            if (strobe_low) n_cmd++;
            else if (addr_valid_o && n_cmd == 0) n_setup++;
            else if (addr_valid_o) n_hold++;
            if (data_drive_o) begin
                n_drive++;
                if (first_drv < 0) first_drv = idx;
            end
            if (done_o) begin
                n_done++;
                done_idx = idx;
            end
            if (idx == rel_idx) wait_n_i = 1'b1;
            if (poke && idx == 2) begin
                start_i = 1'b1; is_write_i = ~wr; timing_i = 32'h0000_0000;
            end
            if (poke && idx == 4) start_i = 1'b0;
            if (done_o) break;
            @(negedge clk);
        end
        @(negedge clk);
        idle_after = !addr_valid_o && we_n_o && re_n_o && !done_o && !data_drive_o;
    endtask

    initial begin
        int s, c, h, d, fd, di, nd, ws;
        logic ia;
        int total;

        // R1: reset state
        #(CLK_PERIOD*3);
        @(negedge clk);
        check(we_n_o && re_n_o, "R1 strobes high in reset", {we_n_o, re_n_o}, 3);
        check(!addr_valid_o && !data_drive_o && !done_o, "R1 outputs low in reset",
              {addr_valid_o, data_drive_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(we_n_o && re_n_o && !addr_valid_o, "R1 idle after reset release",
              {we_n_o, re_n_o, addr_valid_o}, 6);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            run_access(VECS[v].wr, VECS[v].timing, -1, 1'b0, s, c, h, d, fd, di, nd, ws, ia);
            total = VECS[v].e_setup + VECS[v].e_cmd + VECS[v].e_hold;
            check(s == VECS[v].e_setup, "R2 setup length", s, VECS[v].e_setup);
            check(c == VECS[v].e_cmd, "R3 command length", c, VECS[v].e_cmd);
            check(h == VECS[v].e_hold, "R5 hold length", h, VECS[v].e_hold);
            if (VECS[v].wr) begin
                check(d == VECS[v].e_drive, "R6 drive cycles", d, VECS[v].e_drive);
                if (VECS[v].e_drive > 0)
                    check(fd == int'(VECS[v].timing[31:24]), "R6 drive start", fd,
                          int'(VECS[v].timing[31:24]));
            end else begin
                check(d == 0, "R7 read drive cycles", d, 0);
            end
            check(nd == 1 && di == total - 1, "R8 done on last hold cycle", di, total - 1);
            check(ia, "R8 idle after done", ia, 1);
            check(ws == 0, "R10 other strobe quiet", ws, 0);
        end

        // R9: disturbance mid-access
        run_access(1'b1, 32'h0202_0202, -1, 1'b1, s, c, h, d, fd, di, nd, ws, ia);
        check(s == 3 && c == 3 && h == 2, "R9 lengths kept", s*100 + c*10 + h, 332);
        check(d == 6 && ws == 0, "R9 direction kept", d, 6);
        check(ia, "R9 no second access", ia, 1);

        // R11: wait low early, released during setup: no stretch
        @(negedge clk);
        wait_n_i = 1'b0;
        run_access(1'b0, 32'h0000_0503, 0, 1'b0, s, c, h, d, fd, di, nd, ws, ia);
        check(c == 6, "R11 early wait ignored", c, 6);
        check(ia, "R11 idle after", ia, 1);

        // R4: wait low past programmed command time
        @(negedge clk);
        wait_n_i = 1'b0;
        start_i = 1'b1; is_write_i = 1'b0; timing_i = 32'h0000_0000;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 20; k++) @(negedge clk);
        check(!re_n_o && we_n_o, "R4 strobe stretched", re_n_o, 0);
        wait_n_i = 1'b1;
        @(negedge clk);
        check(!re_n_o, "R4 low one edge after release", re_n_o, 0);
        @(negedge clk);
        check(!re_n_o, "R4 low two edges after release", re_n_o, 0);
        @(negedge clk);
        check(re_n_o && addr_valid_o && done_o, "R4 released on third edge",
              {re_n_o, addr_valid_o, done_o}, 7);
        @(negedge clk);
        check(!addr_valid_o && re_n_o && we_n_o, "R8 idle after stretched access",
              addr_valid_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule